// File: doc/BRIEF.md
# Synchronous Flash Burst Read Sequencer with Ready Generation

This block models the device side of a synchronous flash burst read. When chip enable and the address-valid strobe are both low at a clock edge, it captures the start address and a 3-bit wait-state code. It then waits for the initial latency. After that it presents one word per clock from an internal array whose contents are computed from the address, and the address counts up after each word.

Whenever the burst leaves a 64-word row, the last word of the row is held on the bus for two extra clocks and the ready output drops for those clocks. A configuration input picks one of two ready timings. In the first, ready is high in the same cycle as each new word. In the second, ready rises one clock before each new word. Each word comes from the bank that its address falls in. If that bank is flagged busy, the block returns a fixed status word in place of array contents.

The data bus is modelled as a value plus an output-enable. A new strobe during a burst restarts the sequence, and deselecting the chip ends it.

Top module: `burst_rdy_gen`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `rdy` is low. With `ce_n` high, `dout_oe` is low.
- R2: A capture happens at a rising edge where `ce_n` and `avd_n` are both low. With a wait code N, the word at the start address appears on `dout` after the (N+2)th rising edge that follows the capture edge. N counts programmed wait cycles, so the total is N+2.
- R3: Wait codes 6 and 7 behave exactly as code 5, which gives a total latency of 7 clocks.
- R4: After the first word, each rising edge presents the word at the next address, modulo 2^16. The word at address a is the low 16 bits of (a * 0x9E37) XOR 0xA5C3.
- R5: A word whose address has its low six bits all set (0x3F, 0x7F, ...) stays on `dout` for two extra clocks before the next address is presented. The step from 0xFFFF back to 0x0000 is also such a crossing.
- R6: When `rdy_lead` is 0, `rdy` is high exactly in the cycles in which a newly presented word is on `dout`, and it is low during latency and stall cycles. When `rdy_lead` is 1, `rdy` shows that same pattern one clock earlier.
- R7: The bank of a word is address bits [15:14], and bit b of `bank_busy` flags bank b. A word presented while its bank is flagged reads as the status value 0x0080 instead of array data.
- R8: `dout_oe` is high exactly when `ce_n` and `oe_n` are both low. While `dout_oe` is low, `dout` reads 0.
- R9: A new capture during a burst abandons it and restarts the latency count from the new address and wait code.
- R10: A rising edge with `ce_n` high ends any burst. After it, `rdy` stays low and no further words are presented until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock; rising edge is active |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | 16 | Start address of the burst |
| ws_code | input | 3 | Programmed wait-state count |
| rdy_lead | input | 1 | 1 makes ready lead data by one clock |
| bank_busy | input | 4 | One busy flag per bank |
| dout | output | 16 | Burst data word |
| dout_oe | output | 1 | Data bus drive enable |
| rdy | output | 1 | Ready indication to the host |

## Verification
A latency counter that is off by one moves the whole burst by a cycle. That shows as a wrong word on `dout` and a misplaced `rdy` pulse at the first data cycle, two to seven clocks after the capture. A stall counter or boundary decode that goes wrong shows within one to three clocks of the first row-end word, as a word that advances too early or a `rdy` pulse that comes too early or too late. A wrong bank select or a wrong address increment shows as a bad word on the very next presented cycle. The bench compares `dout`, `dout_oe` and `rdy` against its model every clock, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/burst_rdy_pkg.sv
package burst_rdy_pkg;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_LAT  = 2'd1,
        BS_DATA = 2'd2
    } burst_state_e;

    typedef struct packed {
        burst_state_e st;
        logic         fresh;
    } seq_flags_t;

    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_DATA_W    = 16;
    localparam int unsigned DEF_WS_W      = 3;
    localparam int unsigned DEF_WS_MAX    = 5;
    localparam int unsigned DEF_ROW_WORDS = 64;
    localparam int unsigned DEF_STALL     = 2;
    localparam int unsigned DEF_BANK_W    = 2;
    localparam int unsigned LAT_OFFSET    = 2;

    localparam logic [31:0] PAT_MUL = 32'h0000_9E37;
    localparam logic [31:0] PAT_XOR = 32'h0000_A5C3;

    function automatic int unsigned sat_ws(input int unsigned code, input int unsigned cap);
        return (code > cap) ? cap : code;
    endfunction

    function automatic logic [31:0] pattern_word(input logic [31:0] a);
        return (a * PAT_MUL) ^ PAT_XOR;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_rdy_pkg::*;
#(
    parameter int unsigned AW        = DEF_ADDR_W,
    parameter int unsigned WS_W      = DEF_WS_W,
    parameter int unsigned WS_MAX    = DEF_WS_MAX,
    parameter int unsigned ROW_WORDS = DEF_ROW_WORDS,
    parameter int unsigned STALL     = DEF_STALL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          avd_n,
    input  logic [AW-1:0] addr_in,
    input  logic [WS_W-1:0] ws_code,
    output logic          pres_en,
    output logic [AW-1:0] pres_addr,
    output logic [AW-1:0] cur_addr,
    output logic          fresh,
    output logic          fresh_next
);
    localparam int unsigned ROW_BITS = $clog2(ROW_WORDS);
    localparam int unsigned LAT_W    = $clog2(WS_MAX + LAT_OFFSET + 1);
    localparam int unsigned STALL_W  = $clog2(STALL + 1);

    seq_flags_t           flags_q, flags_d;
    logic [LAT_W-1:0]     lat_q, lat_d;
    logic [STALL_W-1:0]   stall_q, stall_d;
    logic [AW-1:0]        addr_q, addr_d;
    logic [LAT_W-1:0]     lat_load;

    function automatic logic row_end(input logic [AW-1:0] a);
        return &a[ROW_BITS-1:0];
    endfunction

    assign lat_load = LAT_W'(sat_ws(32'(ws_code), WS_MAX) + LAT_OFFSET);

    always_comb begin
        flags_d       = flags_q;
        flags_d.fresh = 1'b0;
        lat_d         = lat_q;
        stall_d       = stall_q;
        addr_d        = addr_q;
        pres_en       = 1'b0;
        pres_addr     = addr_q;
        if (ce_n) begin
            flags_d.st = BS_IDLE;
            stall_d    = '0;
        end else if (!avd_n) begin
            flags_d.st = BS_LAT;
            lat_d      = lat_load;
            addr_d     = addr_in;
            stall_d    = '0;
        end else begin
            unique case (flags_q.st)
                BS_LAT: begin
                    if (lat_q == LAT_W'(1)) begin
                        flags_d.st    = BS_DATA;
                        flags_d.fresh = 1'b1;
                        pres_en       = 1'b1;
                        stall_d       = row_end(addr_q) ? STALL_W'(STALL) : '0;
                    end else begin
                        lat_d = lat_q - LAT_W'(1);
                    end
                end
                BS_DATA: begin
                    if (stall_q != '0) begin
                        stall_d = stall_q - STALL_W'(1);
                    end else begin
                        addr_d        = addr_q + AW'(1);
                        pres_addr     = addr_d;
                        pres_en       = 1'b1;
                        flags_d.fresh = 1'b1;
                        stall_d       = row_end(addr_d) ? STALL_W'(STALL) : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{st: BS_IDLE, fresh: 1'b0};
            lat_q   <= '0;
            stall_q <= '0;
            addr_q  <= '0;
        end else begin
            flags_q <= flags_d;
            lat_q   <= lat_d;
            stall_q <= stall_d;
            addr_q  <= addr_d;
        end
    end

    assign cur_addr   = addr_q;
    assign fresh      = flags_q.fresh;
    assign fresh_next = ((flags_q.st == BS_LAT) && (lat_q == LAT_W'(1))) ||
                        ((flags_q.st == BS_DATA) && (stall_q == '0));

endmodule

// File: rtl/burst_word_src.sv
module burst_word_src
    import burst_rdy_pkg::*;
#(
    parameter int unsigned        AW     = DEF_ADDR_W,
    parameter int unsigned        DW     = DEF_DATA_W,
    parameter int unsigned        BANK_W = DEF_BANK_W,
    parameter logic [DW-1:0]      STATUS = DW'(16'h0080)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pres_en,
    input  logic [AW-1:0]         pres_addr,
    input  logic [(1<<BANK_W)-1:0] bank_busy,
    output logic [DW-1:0]         word_q
);
    localparam int unsigned BANKS = 1 << BANK_W;

    logic [BANK_W-1:0] bank;
    logic [BANKS-1:0]  hit;
    logic              busy_hit;
    logic [DW-1:0]     array_word;

    assign bank = pres_addr[AW-1 -: BANK_W];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign hit[b] = bank_busy[b] && (bank == BANK_W'(b));
    end

    assign busy_hit   = |hit;
    assign array_word = DW'(pattern_word(32'(pres_addr)));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (pres_en) begin
            word_q <= busy_hit ? STATUS : array_word;
        end
    end

endmodule

// File: rtl/burst_rdy_sel.sv
module burst_rdy_sel (
    input  logic fresh,
    input  logic fresh_next,
    input  logic rdy_lead,
    output logic rdy
);
    assign rdy = rdy_lead ? fresh_next : fresh;
endmodule

// File: rtl/burst_rdy_gen.sv
module burst_rdy_gen
    import burst_rdy_pkg::*;
#(
    parameter int unsigned AW        = DEF_ADDR_W,
    parameter int unsigned DW        = DEF_DATA_W,
    parameter int unsigned WS_W      = DEF_WS_W,
    parameter int unsigned WS_MAX    = DEF_WS_MAX,
    parameter int unsigned ROW_WORDS = DEF_ROW_WORDS,
    parameter int unsigned STALL     = DEF_STALL,
    parameter int unsigned BANK_W    = DEF_BANK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce_n,
    input  logic                   oe_n,
    input  logic                   avd_n,
    input  logic [AW-1:0]          addr_in,
    input  logic [WS_W-1:0]        ws_code,
    input  logic                   rdy_lead,
    input  logic [(1<<BANK_W)-1:0] bank_busy,
    output logic [DW-1:0]          dout,
    output logic                   dout_oe,
    output logic                   rdy
);
    logic          pres_en;
    logic [AW-1:0] pres_addr;
    logic [AW-1:0] cur_addr;
    logic          fresh;
    logic          fresh_next;
    logic [DW-1:0] word_q;

    burst_seq #(
        .AW(AW), .WS_W(WS_W), .WS_MAX(WS_MAX), .ROW_WORDS(ROW_WORDS), .STALL(STALL)
    ) u_seq (
        .clk(clk), .rst(rst), .ce_n(ce_n), .avd_n(avd_n),
        .addr_in(addr_in), .ws_code(ws_code),
        .pres_en(pres_en), .pres_addr(pres_addr), .cur_addr(cur_addr),
        .fresh(fresh), .fresh_next(fresh_next)
    );

    burst_word_src #(
        .AW(AW), .DW(DW), .BANK_W(BANK_W)
    ) u_src (
        .clk(clk), .rst(rst), .pres_en(pres_en), .pres_addr(pres_addr),
        .bank_busy(bank_busy), .word_q(word_q)
    );

    burst_rdy_sel u_rdy (
        .fresh(fresh), .fresh_next(fresh_next), .rdy_lead(rdy_lead), .rdy(rdy)
    );

    assign dout_oe = !ce_n && !oe_n;
    assign dout    = dout_oe ? word_q : '0;

endmodule

// File: rtl/burst_rdy_chk.sv
module burst_rdy_chk #(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 16,
    parameter int unsigned ROW_WORDS = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          avd_n,
    input logic [AW-1:0] addr_in,
    input logic          rdy_lead,
    input logic [DW-1:0] dout,
    input logic          dout_oe,
    input logic          rdy,
    input logic [AW-1:0] cur_addr,
    input logic          fresh,
    input logic [DW-1:0] word_q
);
    localparam int unsigned ROW_BITS = $clog2(ROW_WORDS);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !rdy);

    a_r2_no_ready_after_capture: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !avd_n) |=> !rdy);

    a_r5_row_end_hold: assert property (@(posedge clk) disable iff (rst)
        (fresh && (&cur_addr[ROW_BITS-1:0]) && !ce_n && avd_n) |=> (!fresh && $stable(word_q)));

    a_r6_lead_precedes_word: assert property (@(posedge clk) disable iff (rst)
        (rdy_lead && rdy && !ce_n && avd_n) |=> fresh);

    a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));

    a_r9_restart_address: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !avd_n) |=> (cur_addr == $past(addr_in)));

    a_r10_deselect_stops: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !fresh);

endmodule

bind burst_rdy_gen burst_rdy_chk #(
    .AW(AW), .DW(DW), .ROW_WORDS(ROW_WORDS)
) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .avd_n(avd_n), .addr_in(addr_in),
    .rdy_lead(rdy_lead), .dout(dout), .dout_oe(dout_oe), .rdy(rdy),
    .cur_addr(cur_addr), .fresh(fresh), .word_q(word_q)
);

// File: tb/burst_rdy_gen_test.sv
module burst_rdy_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b0;
    logic        avd_n = 1'b1;
    logic [15:0] addr_in = 16'h0000;
    logic [2:0]  ws_code = 3'd0;
    logic        rdy_lead = 1'b0;
    logic [3:0]  bank_busy = 4'b0000;
    logic [15:0] dout;
    logic        dout_oe;
    logic        rdy;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    string cur_req = "R1";

    typedef struct {
        bit          valid;
        bit          fresh;
        logic [15:0] word;
    } ent_t;

    ent_t exp_q[$];
    ent_t cur;

    burst_rdy_gen uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .avd_n(avd_n),
        .addr_in(addr_in), .ws_code(ws_code), .rdy_lead(rdy_lead),
        .bank_busy(bank_busy), .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] spec_word(input int a);
        int unsigned prod;
        prod = a * 32'h9E37;
        return prod[15:0] ^ 16'hA5C3;
    endfunction

    task automatic build_burst(input int start, input int code);
        int n;
        int a;
        ent_t e;
        n = (code > 5) ? 5 : code;
        exp_q.delete();
        for (int i = 0; i <= n; i++) begin
            e = '{valid: 1'b0, fresh: 1'b0, word: 16'h0000};
            exp_q.push_back(e);
        end
        a = start;
        while (exp_q.size() < 300) begin
            e.valid = 1'b1;
            e.fresh = 1'b1;
            e.word  = bank_busy[a >> 14] ? 16'h0080 : spec_word(a);
            exp_q.push_back(e);
            if ((a % 64) == 63) begin
                e.fresh = 1'b0;
                exp_q.push_back(e);
                exp_q.push_back(e);
            end
            a = (a + 1) % 65536;
        end
    endtask

    task automatic model_edge();
        if (rst || ce_n) begin
            exp_q.delete();
            cur = '{valid: 1'b0, fresh: 1'b0, word: 16'h0000};
        end else if (!avd_n) begin
            build_burst(int'(addr_in), int'(ws_code));
            cur = '{valid: 1'b0, fresh: 1'b0, word: 16'h0000};
        end else if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
        end else begin
            cur.fresh = 1'b0;
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s dout: got %04h expected %04h", req, got, exp);
        end
    endtask

    task automatic compare();
        logic exp_oe;
        logic exp_rdy;
        exp_oe = !ce_n && !oe_n;
        // R8: bus enable and idle value
        check_bit("R8", "dout_oe", dout_oe, exp_oe);
        if (!exp_oe)
            check_word("R8", dout, 16'h0000);
        else if (cur.valid)
            check_word(cur_req, dout, cur.word);
        if (rdy_lead)
            exp_rdy = (exp_q.size() > 0) ? exp_q[0].fresh : 1'b0;
        else
            exp_rdy = cur.fresh;
        check_bit(cur_req, "rdy", rdy, exp_rdy);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start(input logic [15:0] a, input logic [2:0] code);
        ce_n    = 1'b0;
        avd_n   = 1'b0;
        addr_in = a;
        ws_code = code;
        tick();
        avd_n   = 1'b1;
        addr_in = 16'hDEAD;
        ws_code = 3'd0;
    endtask

    task automatic deselect();
        ce_n = 1'b1;
        run(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        cur = '{valid: 1'b0, fresh: 1'b0, word: 16'h0000};
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        run(3);
        rst = 1'b0;
        run(2);

        // R2: latency for several wait codes
        cur_req = "R2";
        start(16'h0100, 3'd0); run(10); deselect();
        start(16'h0200, 3'd5); run(14); deselect();
        start(16'h0A31, 3'd2); run(10); deselect();

        // R3: saturating codes
        cur_req = "R3";
        start(16'h0010, 3'd7); run(12); deselect();
        start(16'h0020, 3'd6); run(12); deselect();

        // R4: sequential words
        cur_req = "R4";
        start(16'h1234, 3'd1); run(20); deselect();

        // R5: row-end stalls, including wrap to zero
        cur_req = "R5";
        start(16'h003C, 3'd1); run(16); deselect();
        start(16'hFFFD, 3'd0); run(12); deselect();
        start(16'h007F, 3'd3); run(12); deselect();

        // R6: ready leading data
        cur_req = "R6";
        rdy_lead = 1'b1;
        start(16'h007D, 3'd3); run(16); deselect();
        start(16'h00BF, 3'd0); run(10); deselect();
        rdy_lead = 1'b0;

        // R7: busy bank returns status
        cur_req = "R7";
        bank_busy = 4'b0010;
        start(16'h3FFD, 3'd0); run(14); deselect();
        bank_busy = 4'b1000;
        start(16'hC005, 3'd2); run(8); deselect();
        bank_busy = 4'b0000;

        // R8: output enable gating mid-burst
        cur_req = "R8";
        start(16'h0500, 3'd1);
        run(4);
        oe_n = 1'b1; run(3);
        oe_n = 1'b0; run(4);
        deselect();

        // R9: restart during latency and during data
        cur_req = "R9";
        start(16'h0600, 3'd4); run(2);
        start(16'h0700, 3'd0); run(5);
        start(16'h0800, 3'd1); run(6);
        deselect();

        // R10: deselect mid-burst
        cur_req = "R10";
        start(16'h0900, 3'd0); run(4);
        ce_n = 1'b1; run(5);
        rdy_lead = 1'b1; run(3);
        rdy_lead = 1'b0;

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL R1 watchdog: got hung run expected completion");
            finish_run();
        end
    end

endmodule